// File: doc/BRIEF.md
# Interrupt Claim Priority Arbiter

This block is the decision core of an interrupt controller serving a single target context. It keeps, for every source, a pending bit, an enable bit, a claimed bit and a small priority value, plus one priority threshold for the target. From that state it raises an interrupt request line. When the target reads a claim, the block returns the identifier of the best waiting source and commits that choice in the same step.

Sources raise interrupts with single-cycle pulses. Software programs priorities, enables, pending bits and the threshold through a valid/address/data write port. A claim is a one-cycle strobe, and its answer appears on the following cycle. When the target has finished servicing a source, it writes a completion with that source's identifier, and the source can then raise a new request. Identifier 0 is reserved and means that no interrupt is available. The source count must be a power of two and a multiple of 32.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is a candidate only when it is pending, enabled, not claimed, and its priority is strictly greater than the threshold. A priority equal to the threshold does not qualify.
- R2: Among candidates, the claim picks the one with the highest priority. On equal priority, the lowest source identifier wins.
- R3: A claim strobe in cycle t gives claimValid high in cycle t+1, with claimId set to the winner. On the same clock edge the winner's pending bit is cleared and its claimed bit is set. When no claim was strobed, claimValid and claimId are 0.
- R4: A claim that finds no candidate returns identifier 0 and changes no pending or claimed bit.
- R5: irq is high exactly when at least one candidate exists in the current registered state. It therefore follows every state change one cycle after the write, pulse, claim or completion that caused it.
- R6: A source pulse sets the pending bit only if the source is not claimed at that edge. Pulses to claimed sources are dropped. A software pending write cannot set the pending bit of a claimed source either.
- R7: A completion carrying an identifier clears that source's claimed bit. A later pulse can then make the source pending again.
- R8: The write address is {region[1:0], index[5:0]}. Region 00 writes the priority of source index from data[2:0]. Region 01 writes enable word index[0]. Region 10 writes pending word index[0]. Region 11 writes the threshold from data[2:0]. In a word, bit b maps to source word*32+b.
- R9: After reset, all pending, enable and claimed bits are 0, and all priorities and the threshold are 0, so irq is low and claims return 0.
- R10: If a source wins a claim on the same edge that it receives a pulse, it ends claimed and not pending. A completion at that edge for a different source still takes effect.
- R11: Source 0 is never a candidate and is never claimed, whatever its programmed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcPulse | input | 64 | One-cycle interrupt request per source |
| wrValid | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write address: region and index |
| wrData | input | 32 | Write data |
| claimReq | input | 1 | Claim strobe from the target |
| claimValid | output | 1 | Claim answer is valid this cycle |
| claimId | output | 6 | Claimed source identifier, 0 when none |
| completeValid | input | 1 | Completion strobe |
| completeId | input | 6 | Source identifier being completed |
| irq | output | 1 | Interrupt request to the target |

## Verification
The assertions check, on every cycle, the following: the claim answer timing, that a nonzero answer leaves the winner claimed and not pending, that the answer agrees with the irq level seen when the claim was strobed, that irq is high only when some source is pending, enabled and unclaimed, that pending and claimed bits never overlap, and that source 0 is never claimed. Only the bench scenarios can show which source wins. That covers ordering by priority, ties resolved by lowest identifier, and the strict threshold comparison. The same holds for address decoding, the dropping of pulses to claimed sources, and release on completion. The bench compares every clock against a behavioural model under directed and random stimulus.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    REG_PRIO    = 2'b00,
    REG_ENABLE  = 2'b01,
    REG_PENDING = 2'b10,
    REG_THRESH  = 2'b11
  } region_e;

  typedef struct packed {
    logic prioWe;
    logic enWe;
    logic pendWe;
    logic thrWe;
    logic claimGo;
    logic completeGo;
  } ctrlStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        wrValid,
  input  logic [1:0]  regionSel,
  input  logic        claimReq,
  input  logic        completeValid,
  output ctrlStrobe_t strobe
);

  region_e region;

  always_comb begin
    region = region_e'(regionSel);
    strobe = '0;
    strobe.claimGo    = claimReq;
    strobe.completeGo = completeValid;
    if (wrValid) begin
      unique case (region)
        REG_PRIO:    strobe.prioWe = 1'b1;
        REG_ENABLE:  strobe.enWe   = 1'b1;
        REG_PENDING: strobe.pendWe = 1'b1;
        REG_THRESH:  strobe.thrWe  = 1'b1;
        default:     strobe.prioWe = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/arb_search.sv
module arb_search #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC-1:0]             pendQ,
  input  logic [NUM_SRC-1:0]             enQ,
  input  logic [NUM_SRC-1:0]             clmQ,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ,
  input  logic [PRIO_W-1:0]              thrQ,
  output logic                           found,
  output logic [ID_W-1:0]                winId
);

  localparam int NODES = 2 * NUM_SRC - 1;
  localparam int LEAF0 = NUM_SRC - 1;

  logic              nodeValid [NODES];
  logic [PRIO_W-1:0] nodePrio  [NODES];
  logic [ID_W-1:0]   nodeId    [NODES];

  // Leaves in source order; source 0 is reserved and never qualifies.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    if (i == 0) begin : g_reserved
      assign nodeValid[LEAF0] = 1'b0;
    end else begin : g_normal
      assign nodeValid[LEAF0 + i] = pendQ[i] & enQ[i] & ~clmQ[i] & (prioQ[i] > thrQ);
    end
    assign nodePrio[LEAF0 + i] = prioQ[i];
    assign nodeId[LEAF0 + i]   = ID_W'(i);
  end

  // Internal nodes: the left child covers lower identifiers and keeps ties.
  for (genvar n = 0; n < NUM_SRC - 1; n++) begin : g_node
    logic pickRight;
    assign pickRight = nodeValid[2*n+2] &
                       (~nodeValid[2*n+1] | (nodePrio[2*n+2] > nodePrio[2*n+1]));
    assign nodeValid[n] = nodeValid[2*n+1] | nodeValid[2*n+2];
    assign nodePrio[n]  = pickRight ? nodePrio[2*n+2] : nodePrio[2*n+1];
    assign nodeId[n]    = pickRight ? nodeId[2*n+2]   : nodeId[2*n+1];
  end

  assign found = nodeValid[0];
  assign winId = nodeId[0];

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  ctrlStrobe_t                    strobe,
  input  logic [ID_W-1:0]                srcSel,
  input  logic [31:0]                    wrData,
  input  logic [NUM_SRC-1:0]             srcPulse,
  input  logic [ID_W-1:0]                completeId,
  input  logic                           found,
  input  logic [ID_W-1:0]                winId,
  output logic [NUM_SRC-1:0]             pendQ,
  output logic [NUM_SRC-1:0]             enQ,
  output logic [NUM_SRC-1:0]             clmQ,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ,
  output logic [PRIO_W-1:0]              thrQ,
  output logic                           claimValid,
  output logic [ID_W-1:0]                claimId
);

  localparam int NUM_WORDS = NUM_SRC / 32;
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [WIDX_W-1:0]  wordSel;
  logic [NUM_SRC-1:0] wordMask;
  logic [NUM_SRC-1:0] wordData;
  logic [NUM_SRC-1:0] winMask;
  logic [NUM_SRC-1:0] compMask;
  logic [NUM_SRC-1:0] pendBase;
  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] clmNext;

  assign wordSel  = srcSel[WIDX_W-1:0];
  assign wordData = {NUM_WORDS{wrData}};

  always_comb begin
    wordMask = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wordSel == WIDX_W'(w)) wordMask[w*32 +: 32] = '1;
    end
  end

  always_comb begin
    winMask  = (strobe.claimGo && found) ? (NUM_SRC'(1) << winId) : '0;
    compMask = strobe.completeGo ? (NUM_SRC'(1) << completeId) : '0;
    enNext   = strobe.enWe ? ((enQ & ~wordMask) | (wordData & wordMask)) : enQ;
    pendBase = strobe.pendWe ? ((pendQ & ~wordMask) | (wordData & wordMask & ~clmQ)) : pendQ;
    pendNext = (pendBase | (srcPulse & ~clmQ)) & ~winMask;
    clmNext  = (clmQ & ~compMask) | winMask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ      <= '0;
      enQ        <= '0;
      clmQ       <= '0;
      thrQ       <= '0;
      claimValid <= 1'b0;
      claimId    <= '0;
    end else begin
      pendQ      <= pendNext;
      enQ        <= enNext;
      clmQ       <= clmNext;
      claimValid <= strobe.claimGo;
      claimId    <= (strobe.claimGo && found) ? winId : '0;
      if (strobe.thrWe) thrQ <= wrData[PRIO_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prioQ[i] <= '0;
      else if (strobe.prioWe && srcSel == ID_W'(i)) prioQ[i] <= wrData[PRIO_W-1:0];
    end
  end

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC),
  localparam int ADDR_W = ID_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcPulse,
  input  logic               wrValid,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic               claimReq,
  output logic               claimValid,
  output logic [ID_W-1:0]    claimId,
  input  logic               completeValid,
  input  logic [ID_W-1:0]    completeId,
  output logic               irq
);

  ctrlStrobe_t                    strobe;
  logic [NUM_SRC-1:0]             pendQ;
  logic [NUM_SRC-1:0]             enQ;
  logic [NUM_SRC-1:0]             clmQ;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ;
  logic [PRIO_W-1:0]              thrQ;
  logic                           found;
  logic [ID_W-1:0]                winId;

  arb_ctrl u_ctrl (
    .wrValid       (wrValid),
    .regionSel     (wrAddr[ADDR_W-1:ADDR_W-2]),
    .claimReq      (claimReq),
    .completeValid (completeValid),
    .strobe        (strobe)
  );

  arb_search #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_search (
    .pendQ (pendQ),
    .enQ   (enQ),
    .clmQ  (clmQ),
    .prioQ (prioQ),
    .thrQ  (thrQ),
    .found (found),
    .winId (winId)
  );

  arb_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .srcSel     (wrAddr[ID_W-1:0]),
    .wrData     (wrData),
    .srcPulse   (srcPulse),
    .completeId (completeId),
    .found      (found),
    .winId      (winId),
    .pendQ      (pendQ),
    .enQ        (enQ),
    .clmQ       (clmQ),
    .prioQ      (prioQ),
    .thrQ       (thrQ),
    .claimValid (claimValid),
    .claimId    (claimId)
  );

  assign irq = found;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               claimReq,
  input logic               claimValid,
  input logic [ID_W-1:0]    claimId,
  input logic               irq,
  input logic [NUM_SRC-1:0] pendQ,
  input logic [NUM_SRC-1:0] enQ,
  input logic [NUM_SRC-1:0] clmQ
);

  assert_claim_response_R3: assert property (@(posedge clk) disable iff (!rst_n)
    claimReq |=> claimValid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !claimReq |=> (!claimValid && claimId == '0));

  assert_winner_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (claimValid && claimId != '0) |-> (clmQ[claimId] && !pendQ[claimId]));

  assert_claim_matches_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claimValid |-> ($past(irq) == (claimId != '0)));

  assert_irq_needs_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pendQ & enQ & ~clmQ) != '0));

  assert_pend_excl_claimed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ & clmQ) == '0);

  assert_src0_unclaimed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clmQ[0]);

endmodule

bind irq_claim_arbiter arb_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .claimReq   (claimReq),
  .claimValid (claimValid),
  .claimId    (claimId),
  .irq        (irq),
  .pendQ      (pendQ),
  .enQ        (enQ),
  .clmQ       (clmQ)
);

// File: tb/irq_claim_arbiter_test.sv
module irq_claim_arbiter_test;

  localparam int N = 64;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] srcPulse = '0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        claimReq = 1'b0;
  logic        completeValid = 1'b0;
  logic [5:0]  completeId = '0;
  logic        claimValid;
  logic [5:0]  claimId;
  logic        irq;

  bit mPend [N];
  bit mEn   [N];
  bit mClm  [N];
  int mPrio [N];
  int mThr;
  int passCount = 0;
  int totalCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_claim_arbiter uut (
    .clk(clk), .rst_n(rst_n), .srcPulse(srcPulse), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .claimReq(claimReq),
    .claimValid(claimValid), .claimId(claimId),
    .completeValid(completeValid), .completeId(completeId), .irq(irq)
  );

  function automatic int modelWinner();
    int best = 0;
    int bestPrio = mThr;
    for (int i = 1; i < N; i++)
      if (mPend[i] && mEn[i] && !mClm[i] && mPrio[i] > bestPrio) begin
        best = i;
        bestPrio = mPrio[i];
      end
    return best;
  endfunction

  function automatic int modelIrq();
    for (int i = 1; i < N; i++)
      if (mPend[i] && mEn[i] && !mClm[i] && mPrio[i] > mThr) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    totalCount++;
    if (got == exp) passCount++;
    else $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
  endtask

  // One clock: update the model from current inputs, then compare after the edge.
  task automatic step(input string tag);
    int win;
    int expV;
    int expId;
    bit oldClm [N];
    win = modelWinner();
    oldClm = mClm;
    if (wrValid) begin
      case (wrAddr[7:6])
        2'b00: mPrio[wrAddr[5:0]] = int'(wrData[2:0]);
        2'b01: for (int b = 0; b < 32; b++) mEn[int'(wrAddr[0])*32 + b] = wrData[b];
        2'b10: for (int b = 0; b < 32; b++) begin
                 int idx = int'(wrAddr[0])*32 + b;
                 mPend[idx] = wrData[b] && !oldClm[idx];
               end
        default: mThr = int'(wrData[2:0]);
      endcase
    end
    for (int i = 0; i < N; i++) if (srcPulse[i] && !oldClm[i]) mPend[i] = 1'b1;
    if (completeValid) mClm[completeId] = 1'b0;
    if (claimReq && win != 0) begin
      mPend[win] = 1'b0;
      mClm[win] = 1'b1;
    end
    expV = claimReq ? 1 : 0;
    expId = claimReq ? win : 0;
    @(posedge clk);
    @(negedge clk);
    check(tag, "claimValid", int'(claimValid), expV);
    check(tag, "claimId", int'(claimId), expId);
    check(tag, "irq", int'(irq), modelIrq());
    srcPulse = '0; wrValid = 1'b0; wrAddr = '0; wrData = '0;
    claimReq = 1'b0; completeValid = 1'b0; completeId = '0;
  endtask

  task automatic wrReg(input int region, input int idx, input logic [31:0] data, input string tag);
    wrValid = 1'b1;
    wrAddr = {region[1:0], idx[5:0]};
    wrData = data;
    step(tag);
  endtask

  task automatic pulse(input logic [63:0] mask, input string tag);
    srcPulse = mask;
    step(tag);
  endtask

  task automatic claim(input string tag);
    claimReq = 1'b1;
    step(tag);
  endtask

  task automatic complete(input int id, input string tag);
    completeValid = 1'b1;
    completeId = id[5:0];
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    totalCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCount, totalCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mPend[i] = 0; mEn[i] = 0; mClm[i] = 0; mPrio[i] = 0;
    end
    mThr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9", "claimValid", int'(claimValid), 0);
    check("R9", "claimId", int'(claimId), 0);
    check("R9", "irq", int'(irq), 0);
    claim("R9");
    wrReg(1, 0, 32'hFFFF_FFFF, "R9");
    wrReg(1, 1, 32'hFFFF_FFFF, "R9");
    pulse(64'h8, "R9");              // priority 0 not above threshold 0
    claim("R9");

    // R1: threshold is strict
    wrReg(0, 5, 3, "R1");
    wrReg(0, 9, 3, "R1");
    wrReg(0, 40, 6, "R1");
    wrReg(0, 2, 1, "R1");
    wrReg(0, 3, 0, "R1");
    wrReg(3, 0, 1, "R1");
    pulse(64'h4, "R1");              // src2 priority == threshold
    claim("R4");                     // nothing qualifies, returns 0
    // R2: tie broken by lowest id
    pulse((64'h1 << 5) | (64'h1 << 9), "R2");
    claim("R2");
    claim("R2");
    // R6: pulse to claimed source dropped
    pulse((64'h1 << 40) | (64'h1 << 5), "R6");
    claim("R2");
    claim("R6");
    // R7: completion releases
    complete(5, "R7");
    claim("R7");
    pulse(64'h1 << 5, "R7");
    claim("R7");
    // threshold lowered: src2 now qualifies
    wrReg(3, 0, 0, "R1");
    claim("R1");

    // R8: word mapping into the upper enable/pending word
    wrReg(1, 1, 32'h0000_0008, "R8");
    wrReg(0, 35, 2, "R8");
    wrReg(0, 36, 7, "R8");
    pulse((64'h1 << 35) | (64'h1 << 36), "R8");
    claim("R8");
    wrReg(1, 1, 32'h0000_0010, "R8");
    wrReg(2, 1, 32'h0000_0010, "R8");
    claim("R8");
    // R6: software pending write to a claimed source is dropped
    wrReg(2, 1, 32'h0000_0010, "R6");
    claim("R6");

    // R10: pulse to the winner on the claim edge, plus completion of another
    wrReg(1, 0, 32'hFFFF_FFFF, "R10");
    wrReg(0, 12, 5, "R10");
    pulse(64'h1 << 12, "R10");
    claimReq = 1'b1; srcPulse = 64'h1 << 12; completeValid = 1'b1; completeId = 6'd36;
    step("R10");
    complete(12, "R10");
    claim("R10");

    // R11: source 0 never wins
    wrReg(0, 0, 7, "R11");
    wrReg(2, 0, 32'h0000_0001, "R11");
    pulse(64'h1, "R11");
    claim("R11");

    // Mixed random traffic against the model
    for (int k = 0; k < 400; k++) begin
      srcPulse = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      claimReq = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) begin
        wrValid = 1'b1;
        wrAddr = 8'($urandom);
        wrData = $urandom;
      end
      if (($urandom % 4) == 0) begin
        completeValid = 1'b1;
        completeId = 6'($urandom);
      end
      step("R2");
    end

    $display("%0d/%0d checks passed", passCount, totalCount);
    $finish;
  end

endmodule